// File: doc/BRIEF.md
# Priority Interrupt Vector Unit

This block sits between a set of peripheral ports and a processor. It takes eight active-low request lines, one for each priority level, and registers them on every clock. While any request is pending it holds an active-high interrupt line to the processor. The highest pending level, with level 7 the most urgent, is encoded into a 3-bit code.

When the processor acknowledges the interrupt, the block captures the winning code on the rising edge of acknowledge. It then presents a one-byte restart opcode built from that code. The byte and its drive enable are active only while acknowledge is held and the processor reads the bus. The captured code stays fixed until acknowledge drops, so a request that arrives during the read cannot change the byte.

Top module: `irq_vector_unit`

## Requirements
- R1: Each bit of `req_n` is an active-low request for the level equal to its bit index. The lines are sampled on every rising clock edge.
- R2: `irq` is high in the cycle after a clock edge that sampled at least one low request line, and low otherwise.
- R3: When several requests are pending, the captured level is the highest-numbered one (level 7 wins, level 0 loses).
- R4: The driven byte is binary `11`, then the 3-bit level, then `111`. Examples: level 0 gives 0xC7, level 2 gives 0xD7, level 5 gives 0xEF, level 6 gives 0xF7, level 7 gives 0xFF.
- R5: `vec_oe` is high only while `dbin` is high and `inta` was high at the last clock edge. While `vec_oe` is low, `vec_byte` is zero.
- R6: The level is captured at the first clock edge that sees `inta` high after it was low, using the requests registered before that edge. Later request changes do not alter `vec_byte` until `inta` falls and rises again.
- R7: If no request was pending at the capture edge, `vec_oe` stays low for the whole acknowledge.
- R8: While `rst_n` is low, `irq`, `vec_oe` and `vec_byte` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_n | input | NUM_LEVELS | Request lines, active low, bit index = level |
| inta | input | 1 | Interrupt acknowledge from the processor, active high |
| dbin | input | 1 | Processor bus read strobe, active high |
| irq | output | 1 | Interrupt to the processor, active high |
| vec_byte | output | DATA_W | Restart opcode, zero when not driven |
| vec_oe | output | 1 | Bus drive enable for `vec_byte` |

## Verification
The bench builds the block with its default of eight levels and an 8-bit data path. With these values every level code and every restart opcode from 0xC7 to 0xFF can be reached. Random request patterns, mixed with acknowledge and read pulses, reach every winner of the priority encoder. They also exercise acknowledges that start with nothing pending and requests that change during an acknowledge. Directed sequences pin the captured code across a mid-acknowledge request and check the exact opcode values listed in R4.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
    localparam int unsigned DEF_LEVELS = 8;
    localparam int unsigned DEF_DATA_W = 8;
    // width of the constant ones field below the level code
    localparam int unsigned SUFFIX_W   = 3;

    function automatic int unsigned prefix_width(int unsigned data_w, int unsigned code_w);
        return data_w - code_w - SUFFIX_W;
    endfunction
endpackage

// File: rtl/irq_vec_prio_enc.sv
module irq_vec_prio_enc #(
    parameter int unsigned NUM_LEVELS = irq_vec_pkg::DEF_LEVELS
) (
    input  logic [NUM_LEVELS-1:0]         pend,
    output logic                          any,
    output logic [$clog2(NUM_LEVELS)-1:0] code
);
    localparam int unsigned CODE_W = $clog2(NUM_LEVELS);

    logic [NUM_LEVELS:0]   above;
    logic [NUM_LEVELS-1:0] grant;

    assign above[NUM_LEVELS] = 1'b0;

    // grant chain: a level wins only when nothing above it is pending
    for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_chain
        assign above[g] = above[g+1] | pend[g];
        assign grant[g] = pend[g] & ~above[g+1];
    end

    assign any = above[0];

    always_comb begin
        code = '0;
        for (int i = 0; i < NUM_LEVELS; i++) begin
            if (grant[i]) code = code | CODE_W'(i);
        end
    end
endmodule

// File: rtl/irq_vec_opcode_fmt.sv
module irq_vec_opcode_fmt #(
    parameter int unsigned CODE_W = 3,
    parameter int unsigned DATA_W = irq_vec_pkg::DEF_DATA_W
) (
    input  logic [CODE_W-1:0] code,
    input  logic              en,
    output logic [DATA_W-1:0] opcode
);
    localparam int unsigned SFX_W = irq_vec_pkg::SUFFIX_W;
    localparam int unsigned PFX_W = irq_vec_pkg::prefix_width(DATA_W, CODE_W);

    logic [DATA_W-1:0] raw;

    assign raw    = {{PFX_W{1'b1}}, code, {SFX_W{1'b1}}};
    assign opcode = en ? raw : '0;
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit #(
    parameter int unsigned NUM_LEVELS = irq_vec_pkg::DEF_LEVELS,
    parameter int unsigned DATA_W     = irq_vec_pkg::DEF_DATA_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_LEVELS-1:0] req_n,
    input  logic                  inta,
    input  logic                  dbin,
    output logic                  irq,
    output logic [DATA_W-1:0]     vec_byte,
    output logic                  vec_oe
);
    localparam int unsigned CODE_W = $clog2(NUM_LEVELS);

    typedef struct packed {
        logic [NUM_LEVELS-1:0] pend;
        logic                  ack;
        logic [CODE_W-1:0]     code;
        logic                  valid;
    } state_t;

    state_t st_d, st_q;

    logic              enc_any;
    logic [CODE_W-1:0] enc_code;
    logic              drive;

    irq_vec_prio_enc #(.NUM_LEVELS(NUM_LEVELS)) u_enc (
        .pend (st_q.pend),
        .any  (enc_any),
        .code (enc_code)
    );

    always_comb begin
        st_d      = st_q;
        st_d.pend = ~req_n;
        st_d.ack  = inta;
        // capture on the first cycle of acknowledge only
        if (inta && !st_q.ack) begin
            st_d.code  = enc_code;
            st_d.valid = enc_any;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq    = enc_any;
    assign drive  = st_q.ack & st_q.valid & dbin;
    assign vec_oe = drive;

    irq_vec_opcode_fmt #(.CODE_W(CODE_W), .DATA_W(DATA_W)) u_fmt (
        .code   (st_q.code),
        .en     (drive),
        .opcode (vec_byte)
    );
endmodule

// File: rtl/irq_vector_unit_chk.sv
module irq_vector_unit_chk #(
    parameter int unsigned NUM_LEVELS = 8,
    parameter int unsigned DATA_W     = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_LEVELS-1:0] req_n,
    input logic                  inta,
    input logic                  dbin,
    input logic                  irq,
    input logic [DATA_W-1:0]     vec_byte,
    input logic                  vec_oe
);
    logic warm_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) warm_q <= 1'b0;
        else        warm_q <= 1'b1;
    end

    assert_irq_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n || !warm_q)
        irq == $past(|(~req_n)));

    assert_oe_needs_read_R5: assert property (@(posedge clk) disable iff (!rst_n || !warm_q)
        vec_oe |-> (dbin && $past(inta)));

    assert_idle_bus_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_oe |-> (vec_byte == '0));

    assert_opcode_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
        vec_oe |-> (vec_byte[DATA_W-1 -: 2] == 2'b11 && vec_byte[2:0] == 3'b111));

    assert_byte_held_R6: assert property (@(posedge clk) disable iff (!rst_n || !warm_q)
        (vec_oe && $past(vec_oe)) |-> $stable(vec_byte));

    always_comb begin
        if (!rst_n) begin
            assert_reset_quiet_R8: assert (!irq && !vec_oe);
        end
    end
endmodule

bind irq_vector_unit irq_vector_unit_chk #(.NUM_LEVELS(NUM_LEVELS), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_n    (req_n),
    .inta     (inta),
    .dbin     (dbin),
    .irq      (irq),
    .vec_byte (vec_byte),
    .vec_oe   (vec_oe)
);

// File: tb/sim_irq_vector_unit.sv
module sim_irq_vector_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] req_n = 8'hFF;
    logic       inta = 1'b0;
    logic       dbin = 1'b0;
    logic       irq;
    logic [7:0] vec_byte;
    logic       vec_oe;

    int n_chk = 0;
    int n_bad = 0;

    // bench model state
    logic [7:0] m_pend = '0;
    logic       m_ack = 1'b0;
    logic [2:0] m_code = '0;
    logic       m_valid = 1'b0;

    irq_vector_unit u0 (
        .clk(clk), .rst_n(rst_n), .req_n(req_n), .inta(inta), .dbin(dbin),
        .irq(irq), .vec_byte(vec_byte), .vec_oe(vec_oe)
    );

    always #2 clk = ~clk;

    function automatic logic [2:0] top_level(logic [7:0] p);
        logic [2:0] c = 3'd0;
        for (int i = 0; i < 8; i++) if (p[i]) c = 3'(i);
        return c;
    endfunction

    function automatic logic [7:0] rst_op(logic [2:0] lvl);
        return {2'b11, lvl, 3'b111};
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one clock: update the model at the edge, compare just after it
    task automatic cyc(string tag);
        logic e_oe;
        @(posedge clk);
        if (!rst_n) begin
            m_pend = '0; m_ack = 0; m_code = '0; m_valid = 0;
        end else begin
            if (inta && !m_ack) begin
                m_code  = top_level(m_pend);
                m_valid = |m_pend;
            end
            m_pend = ~req_n;
            m_ack  = inta;
        end
        #1;
        e_oe = m_ack & m_valid & dbin;
        chk({tag, " R2 irq"}, {7'd0, irq}, {7'd0, |m_pend});
        chk({tag, " R5 oe"}, {7'd0, vec_oe}, {7'd0, e_oe});
        chk({tag, " R4/R6 byte"}, vec_byte, e_oe ? rst_op(m_code) : 8'h00);
    endtask

    task automatic read_level(logic [7:0] rq, logic [7:0] exp_byte, string tag);
        req_n = rq; inta = 0; dbin = 0;
        cyc(tag); cyc(tag);
        inta = 1; dbin = 1;
        cyc(tag);
        chk({tag, " literal"}, vec_byte, exp_byte);
        inta = 0; dbin = 0;
        cyc(tag);
    endtask

    initial begin
        #200000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        req_n = 8'h00; inta = 1; dbin = 1;
        cyc("R8 reset"); cyc("R8 reset");
        chk("R8 reset irq", {7'd0, irq}, 8'd0);
        chk("R8 reset byte", vec_byte, 8'd0);
        #0; req_n = 8'hFF; inta = 0; dbin = 0;
        cyc("R8 reset");
        rst_n = 1;
        cyc("idle"); cyc("idle");

        // R1: single low line raises irq one cycle later
        req_n = 8'b1111_0111;
        cyc("R1 single");
        chk("R1 irq high", {7'd0, irq}, 8'd1);
        req_n = 8'hFF;
        cyc("R1 release");
        chk("R1 irq low", {7'd0, irq}, 8'd0);

        // R4 literal opcodes, R3 priority
        read_level(8'b1111_1110, 8'hC7, "R4 level0");
        read_level(8'b1101_1111, 8'hEF, "R4 level5");
        read_level(8'b0111_1111, 8'hFF, "R4 level7");
        read_level(8'b0000_0000, 8'hFF, "R3 all pending");
        read_level(8'b1011_1010, 8'hF7, "R3 mixed");

        // R5: acknowledge without read, then read without acknowledge
        req_n = 8'b1111_1011; cyc("R5"); cyc("R5");
        inta = 1; dbin = 0; cyc("R5 no read");
        chk("R5 no read oe", {7'd0, vec_oe}, 8'd0);
        inta = 0; dbin = 1; cyc("R5 no ack"); cyc("R5 no ack");
        chk("R5 no ack byte", vec_byte, 8'd0);
        dbin = 0; cyc("R5");

        // R6: level 2 captured, level 6 arrives mid acknowledge
        req_n = 8'b1111_1011; cyc("R6"); cyc("R6");
        inta = 1; dbin = 1; cyc("R6 capture");
        chk("R6 first", vec_byte, 8'hD7);
        req_n = 8'b1011_1011; cyc("R6 hold"); cyc("R6 hold");
        chk("R6 held", vec_byte, 8'hD7);
        inta = 0; dbin = 0; cyc("R6 drop");
        inta = 1; dbin = 1; cyc("R6 recapture");
        chk("R6 new", vec_byte, 8'hF7);
        inta = 0; dbin = 0; cyc("R6");

        // R7: nothing pending at capture
        req_n = 8'hFF; cyc("R7"); cyc("R7");
        inta = 1; dbin = 1; cyc("R7 ack");
        req_n = 8'h00; cyc("R7 late req"); cyc("R7 late req");
        chk("R7 oe stays low", {7'd0, vec_oe}, 8'd0);
        inta = 0; dbin = 0; cyc("R7");

        // constrained random
        for (int k = 0; k < 3000; k++) begin
            logic [7:0] r;
            r = 8'hFF;
            for (int b = 0; b < 8; b++) if ($urandom_range(0, 5) == 0) r[b] = 1'b0;
            if ($urandom_range(0, 3) == 0) req_n = r;
            if ($urandom_range(0, 4) == 0) inta = ~inta;
            dbin = ($urandom_range(0, 2) != 0) ? inta : 1'b0;
            if ($urandom_range(0, 9) == 0) dbin = $urandom_range(0, 1) == 1;
            cyc("rand");
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule